// File: doc/BRIEF.md
# Inner-Privilege Stack Pointer Fetch Unit

This unit serves a control transfer that moves execution to a more privileged level. It takes the current privilege level, the target level, the current stack selector and stack offset, and the base address of the active task-state block. When the target level is numerically lower than the current level, it reads the stack pointer saved for that level from the task-state block. It then returns the new stack selector and offset. It also returns the outgoing selector and offset so that the caller can push them onto the new stack.

The task-state block keeps one 8-byte slot for each of levels 0, 1 and 2. A slot holds a 32-bit offset word followed by a 32-bit word whose low 16 bits are the selector. Level 3 has no slot. The unit only reads memory, over a 32-bit req/ack port. It never writes a slot back, so each inward entry starts from the stored pointer and treats the stack as empty. Selector validation, the push itself and outward returns are handled elsewhere.

Top module: `priv_stack_fetch`

## Requirements
- R1: After reset, `valid_o`, `err_o`, `bypass_o`, `busy_o` and `mem_req_o` are all low.
- R2: A start with `tgt_pl_i < cur_pl_i` and `tgt_pl_i` not 3 issues a first read at `tsb_base_i + 4 + 8*tgt_pl_i`.
- R3: After the first read is acknowledged, a second read is issued at `tsb_base_i + 8 + 8*tgt_pl_i`.
- R4: In the cycle after the second acknowledge, `valid_o` is high for exactly one cycle. At that point `new_esp_o` equals the first word read and `new_ss_o` equals bits 15:0 of the second word.
- R5: `old_ss_o` and `old_esp_o` hold the `cur_ss_i` and `cur_esp_i` values sampled when the start was accepted.
- R6: A start with `tgt_pl_i` equal to 3 raises `err_o` for one cycle in the cycle after the start and issues no memory read.
- R7: A start with `tgt_pl_i >= cur_pl_i` (target not 3) raises `bypass_o` for one cycle after the start. It issues no read and leaves `new_ss_o` and `new_esp_o` unchanged.
- R8: While `mem_req_o` is high and `mem_ack_i` is low, the request stays high and `mem_addr_o` stays stable.
- R9: A start that arrives while `busy_o` is high is ignored. It produces no response, and the old and new pointer outputs keep the values of the request in progress.
- R10: Every inward entry reads the slot from memory again. A repeated request returns the current memory contents, not a value kept from an earlier entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request, sampled when idle |
| cur_pl_i | input | 2 | Current privilege level |
| tgt_pl_i | input | 2 | Target privilege level |
| cur_ss_i | input | 16 | Current stack selector |
| cur_esp_i | input | 32 | Current stack offset |
| tsb_base_i | input | 32 | Task-state block base address |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| valid_o | output | 1 | One-cycle pulse: new pointer ready |
| err_o | output | 1 | One-cycle pulse: target level has no slot |
| bypass_o | output | 1 | One-cycle pulse: not an inward transfer, no fetch |
| new_ss_o | output | 16 | Fetched stack selector |
| new_esp_o | output | 32 | Fetched stack offset |
| old_ss_o | output | 16 | Outgoing stack selector to push |
| old_esp_o | output | 32 | Outgoing stack offset to push |

## Verification
The assertions check the cycle-level rules on every cycle:
- a pending request holds its address until it is acknowledged;
- `valid_o` is a single pulse that follows the second acknowledge;
- `err_o` and `bypass_o` never coincide with a memory request;
- a start while busy produces no response pulse.

Only the bench scenarios can show that the read addresses match the slot layout for each level, and that the selector is taken from the low half of its word. The same holds for which of err, bypass or fetch each combination of levels selects. The scenarios also show that a repeated entry picks up changed memory contents, and that a start ignored while busy leaves the captured outgoing pointer untouched.

// File: rtl/priv_stack_pkg.sv
package priv_stack_pkg;
  localparam int unsigned PL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_OFF = 2'd1,
    ST_RD_SEL = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/priv_stack_addr.sv
module priv_stack_addr #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned SLOT_BYTES = 8,
  parameter int unsigned AREA_OFS   = 4
) (
  input  logic [AW-1:0]                  base_i,
  input  logic [priv_stack_pkg::PL_W-1:0] lvl_i,
  input  logic                           sel_phase_i,
  output logic [AW-1:0]                  addr_o
);
  localparam int unsigned WORD_BYTES = DW / 8;

  logic [AW-1:0] slot_ofs;
  logic [AW-1:0] word_ofs;

  always_comb begin
    slot_ofs = AW'(AREA_OFS) + AW'(SLOT_BYTES) * AW'(lvl_i);
    word_ofs = sel_phase_i ? AW'(WORD_BYTES) : '0;
    addr_o   = base_i + slot_ofs + word_ofs;
  end
endmodule

// File: rtl/priv_stack_ctrl.sv
module priv_stack_ctrl #(
  parameter int unsigned NUM_INNER = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [priv_stack_pkg::PL_W-1:0] cur_pl_i,
  input  logic [priv_stack_pkg::PL_W-1:0] tgt_pl_i,
  input  logic                            ack_i,
  output logic                            accept_o,
  output logic                            req_o,
  output logic                            sel_phase_o,
  output logic                            cap_off_o,
  output logic                            cap_sel_o,
  output logic                            busy_o,
  output logic                            valid_o,
  output logic                            err_o,
  output logic                            bypass_o
);
  import priv_stack_pkg::*;

  fetch_state_e state_q;
  logic valid_q, err_q, byp_q;
  logic no_slot, inward;

  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign no_slot     = int'(tgt_pl_i) >= NUM_INNER;
  assign inward      = tgt_pl_i < cur_pl_i;
  assign req_o       = state_q != ST_IDLE;
  assign busy_o      = req_o;
  assign sel_phase_o = state_q == ST_RD_SEL;
  assign cap_off_o   = (state_q == ST_RD_OFF) && ack_i;
  assign cap_sel_o   = (state_q == ST_RD_SEL) && ack_i;
  assign valid_o     = valid_q;
  assign err_o       = err_q;
  assign bypass_o    = byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      byp_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          if (no_slot)     err_q   <= 1'b1;
          else if (inward) state_q <= ST_RD_OFF;
          else             byp_q   <= 1'b1;
        end
        ST_RD_OFF: if (ack_i) state_q <= ST_RD_SEL;
        ST_RD_SEL: if (ack_i) begin
          state_q <= ST_IDLE;
          valid_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: request and phase held until acknowledged
  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(sel_phase_o));
  // R4: single-cycle valid, only after the selector-word acknowledge
  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r4_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(ack_i && sel_phase_o));
  // R6: level-3 target flagged, no fetch running
  a_r6_err_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_o && $past(tgt_pl_i) == 2'd3);
  // R7: bypass never with a fetch
  a_r7_bypass_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> !req_o);
  // R9: start during a fetch yields no immediate response
  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !err_o && !bypass_o);
  a_r1_onehot_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, err_o, bypass_o}));
endmodule

// File: rtl/priv_stack_fetch.sv
module priv_stack_fetch #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned SLOT_BYTES = 8,
  parameter int unsigned AREA_OFS   = 4,
  parameter int unsigned NUM_INNER  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       cur_pl_i,
  input  logic [1:0]       tgt_pl_i,
  input  logic [SEL_W-1:0] cur_ss_i,
  input  logic [DW-1:0]    cur_esp_i,
  input  logic [AW-1:0]    tsb_base_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             bypass_o,
  output logic [SEL_W-1:0] new_ss_o,
  output logic [DW-1:0]    new_esp_o,
  output logic [SEL_W-1:0] old_ss_o,
  output logic [DW-1:0]    old_esp_o
);
  import priv_stack_pkg::*;

  logic            accept, sel_phase, cap_off, cap_sel;
  logic [PL_W-1:0] lvl_q;
  logic [AW-1:0]   base_q;

  priv_stack_ctrl #(.NUM_INNER(NUM_INNER)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cur_pl_i, .tgt_pl_i,
    .ack_i(mem_ack_i), .accept_o(accept), .req_o(mem_req_o),
    .sel_phase_o(sel_phase), .cap_off_o(cap_off), .cap_sel_o(cap_sel),
    .busy_o, .valid_o, .err_o, .bypass_o
  );

  priv_stack_addr #(.AW(AW), .DW(DW), .SLOT_BYTES(SLOT_BYTES), .AREA_OFS(AREA_OFS)) u_addr (
    .base_i(base_q), .lvl_i(lvl_q), .sel_phase_i(sel_phase), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= '0;
      base_q    <= '0;
      old_ss_o  <= '0;
      old_esp_o <= '0;
      new_ss_o  <= '0;
      new_esp_o <= '0;
    end else begin
      if (accept) begin
        lvl_q     <= tgt_pl_i;
        base_q    <= tsb_base_i;
        old_ss_o  <= cur_ss_i;
        old_esp_o <= cur_esp_i;
      end
      if (cap_off) new_esp_o <= mem_rdata_i;
      if (cap_sel) new_ss_o  <= mem_rdata_i[SEL_W-1:0];
    end
  end

  // R8: address stable while a read waits
  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o));
  // R5: outgoing pointer frozen during a fetch
  a_r5_old_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(old_ss_o) && $stable(old_esp_o));
endmodule

// File: tb/priv_stack_fetch_bench.sv
module priv_stack_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cur_pl = '0, tgt_pl = '0;
  logic [15:0] cur_ss = '0;
  logic [31:0] cur_esp = '0, base = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, valid, err, bypass;
  logic [15:0] new_ss, old_ss;
  logic [31:0] new_esp, old_esp;

  always #4 clk = ~clk;

  priv_stack_fetch u_priv_stack_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cur_pl_i(cur_pl), .tgt_pl_i(tgt_pl),
    .cur_ss_i(cur_ss), .cur_esp_i(cur_esp), .tsb_base_i(base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .valid_o(valid), .err_o(err), .bypass_o(bypass),
    .new_ss_o(new_ss), .new_esp_o(new_esp), .old_ss_o(old_ss), .old_esp_o(old_esp)
  );

  typedef struct {
    int          kind;  // 0 valid, 1 err, 2 bypass
    logic [15:0] ss;
    logic [31:0] esp;
    logic [15:0] oss;
    logic [31:0] oesp;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  int checks = 0, fails = 0, resp_cnt = 0, cycles = 0, lat = 0, wcnt = 0;
  logic [7:0]  gen = 8'h00;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [15:0] last_ss = '0;
  logic [31:0] last_esp = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [7:0] g);
    return (a * 32'h9E37_79B1) ^ {g, 24'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // memory model and address checker
  always @(negedge clk) begin
    if (mem_req) begin
      if (pend) chk("R8 addr held", mem_addr, pend_addr);
      else if (addr_q.size() == 0) chk("R6/R7 unexpected read", mem_addr, 32'hFFFF_FFFF);
      else chk("R2/R3 read address", mem_addr, addr_q.pop_front());
      if (wcnt >= lat) begin
        mem_ack = 1'b1; mem_rdata = mem_word(mem_addr, gen); pend = 1'b0; wcnt = 0;
      end else begin
        mem_ack = 1'b0; pend = 1'b1; pend_addr = mem_addr; wcnt++;
      end
    end else begin
      mem_ack = 1'b0; pend = 1'b0; wcnt = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (valid || err || bypass)) begin
      exp_t e;
      int k;
      k = valid ? 0 : (err ? 1 : 2);
      resp_cnt++;
      if (exp_q.size() == 0) chk("R9 unexpected response", 32'(k), 32'hDEAD);
      else begin
        e = exp_q.pop_front();
        chk("R4/R6/R7 response kind", 32'(k), 32'(e.kind));
        chk("R1 single response flag", 32'(valid + err + bypass), 32'd1);
        chk("R4/R7/R10 new_ss", 32'(new_ss), 32'(e.ss));
        chk("R4/R7/R10 new_esp", new_esp, e.esp);
        chk("R5 old_ss", 32'(old_ss), 32'(e.oss));
        chk("R5 old_esp", old_esp, e.oesp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] c, input logic [1:0] t, input logic [15:0] ss,
                       input logic [31:0] esp, input logic [31:0] b, input bit wait_resp);
    exp_t e;
    int   target;
    e.oss = ss; e.oesp = esp;
    if (t == 2'd3) begin
      e.kind = 1; e.ss = last_ss; e.esp = last_esp;
    end else if (t < c) begin
      e.kind = 0;
      e.esp = mem_word(b + 32'd4 + 32'd8 * 32'(t), gen);
      e.ss  = mem_word(b + 32'd8 + 32'd8 * 32'(t), gen) & 32'hFFFF;
      addr_q.push_back(b + 32'd4 + 32'd8 * 32'(t));
      addr_q.push_back(b + 32'd8 + 32'd8 * 32'(t));
      last_ss = e.ss; last_esp = e.esp;
    end else begin
      e.kind = 2; e.ss = last_ss; e.esp = last_esp;
    end
    exp_q.push_back(e);
    target = resp_cnt + 1;
    @(negedge clk);
    start = 1'b1; cur_pl = c; tgt_pl = t; cur_ss = ss; cur_esp = esp; base = b;
    @(negedge clk);
    start = 1'b0;
    if (wait_resp) begin
      while (resp_cnt < target) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(valid), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 bypass", 32'(bypass), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: inward fetches, various levels and wait states
    lat = 0; issue(2'd3, 2'd0, 16'h002B, 32'h0000_F000, 32'h0000_1000, 1);
    lat = 2; issue(2'd3, 2'd1, 16'h1234, 32'h8000_0010, 32'h0002_0000, 1);
    lat = 1; issue(2'd2, 2'd1, 16'hBEEF, 32'h0000_7FFC, 32'h00AB_C000, 1);
    lat = 3; issue(2'd1, 2'd0, 16'h0F0F, 32'hFFFF_FFF0, 32'hFFFF_FFE0, 1);
    lat = 0; issue(2'd3, 2'd2, 16'h0033, 32'h1234_5678, 32'h0000_0400, 1);

    // R6: target level 3
    issue(2'd3, 2'd3, 16'h0101, 32'h0000_0101, 32'h0000_2000, 1);
    issue(2'd0, 2'd3, 16'h0202, 32'h0000_0202, 32'h0000_2000, 1);

    // R7: same level and outward
    issue(2'd1, 2'd1, 16'h0303, 32'h0000_0303, 32'h0000_3000, 1);
    issue(2'd0, 2'd2, 16'h0404, 32'h0000_0404, 32'h0000_3000, 1);
    issue(2'd2, 2'd2, 16'h0505, 32'h0000_0505, 32'h0000_3000, 1);

    // R9: start while busy is ignored
    lat = 3;
    issue(2'd3, 2'd0, 16'h0A0A, 32'h0000_0A0A, 32'h0000_5000, 0);
    @(negedge clk);
    start = 1'b1; cur_pl = 2'd3; tgt_pl = 2'd3; cur_ss = 16'hDDDD; cur_esp = 32'hDDDD_DDDD;
    @(negedge clk);
    start = 1'b1; tgt_pl = 2'd2; cur_pl = 2'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    chk("R9 pending responses", 32'(exp_q.size()), 0);
    chk("R9 old_ss kept", 32'(old_ss), 32'h0A0A);
    chk("R9 old_esp kept", old_esp, 32'h0000_0A0A);

    // R10: repeated entry re-reads changed memory
    lat = 1;
    gen = 8'h5C;
    issue(2'd3, 2'd0, 16'h0A0A, 32'h0000_0A0A, 32'h0000_5000, 1);
    gen = 8'hC3;
    issue(2'd3, 2'd0, 16'h0A0A, 32'h0000_0A0A, 32'h0000_5000, 1);

    repeat (5) @(negedge clk);
    chk("R3 all reads issued", 32'(addr_q.size()), 0);
    chk("R4 all responses seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule